// File: doc/BRIEF.md
# Three-wire serial EEPROM command master

This block drives a small three-wire serial EEPROM (select, clock, data toward the part, data from the part) on behalf of a host. The host presents one command at a time on a valid/ready handshake: an operation code, a byte offset and, for writes, the data. The block builds the serial instruction and shifts it out most significant bit first. For reads it then shifts the returned data in. It raises `done` for one cycle when the command has finished on the wire.

The memory holds 128 bytes. It is organised either as 128 bytes or as 64 sixteen-bit words, chosen by the static input `mode_x16`. The organisation decides the instruction length, the address mapping and the data width. Three commands carry no address: write unlock, write lock and wipe-all. They put a two-bit sub-code in the top of the address field. With `long_instr` set, these three commands are extended by two trailing zero bits. After a write or a wipe, the block holds select low for a programming wait before it accepts anything new. After every other command it holds select low for a shorter idle gap.

Top module: `uwire_eeprom_ctrl`

## Requirements
- R1: Every instruction begins with a 1 bit followed by a two-bit opcode: 10 for read (`req_op`=0), 01 for write (`req_op`=1), 00 for unlock (`req_op`=2), lock (`req_op`=3) and wipe-all (`req_op`=4).
- R2: In byte mode (`mode_x16`=0) the address field is 7 bits and equals `req_offset[6:0]`, so the instruction is 10 bits long.
- R3: In word mode (`mode_x16`=1) the address field is 6 bits and equals `req_offset[6:1]`; the instruction is 9 bits long and offset bit 0 has no effect on what is sent or read.
- R4: Unlock, lock and wipe-all put the sub-code 11, 00 and 10 respectively in the two most significant address bits and zeros in the remaining address bits.
- R5: With `long_instr`=1 the three address-free commands gain two trailing zero bits; read and write instructions keep their length.
- R6: A write sends `req_wdata[7:0]` (byte mode) or `req_wdata[15:0]` (word mode) right after the instruction, most significant bit first.
- R7: A read clocks 8 (byte mode) or 16 (word mode) bits in after the instruction, most significant bit first. Each bit is taken from `ee_do` at a rising edge of `ee_sk`. The bits are returned on `rdata`, zero-extended in byte mode. `rdata` is valid when `done` pulses, and `done` lasts one cycle.
- R8: After a write or wipe-all, `ee_cs` stays low and `req_ready` stays low for at least `PROG_WAIT_CYC` clock cycles.
- R9: After any other command, `ee_cs` stays low for at least `CS_IDLE_CYC` cycles before the next command raises it.
- R10: A read or write with `req_offset` of 128 or more, or an opcode above 4, is answered the next cycle with `done` and `err` both high, and `ee_cs` never rises for it.
- R11: `req_ready` is low while a command is on the wire or a wait is running, so requests are held off.
- R12: `ee_di` changes only while `ee_sk` is low, so it is driven at falling edges; `ee_sk` is low whenever `ee_cs` is low.
- R13: In and right after reset, `ee_cs`, `ee_sk` and `done` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_x16 | input | 1 | Static organisation: 0 byte, 1 sixteen-bit word |
| long_instr | input | 1 | Adds two zero bits to address-free commands |
| req_valid | input | 1 | Host command present |
| req_ready | output | 1 | Block can accept a command |
| req_op | input | 3 | 0 read, 1 write, 2 unlock, 3 lock, 4 wipe-all |
| req_offset | input | 8 | Byte offset |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Rejected command, valid with done |
| rdata | output | 16 | Read result |
| ee_cs | output | 1 | Serial chip select, active high |
| ee_sk | output | 1 | Serial clock |
| ee_di | output | 1 | Serial data toward the memory |
| ee_do | input | 1 | Serial data from the memory |

## Verification
The bench builds the block with a serial half-period of 2 clocks, an idle gap of 5 cycles and a programming wait of 60 cycles instead of the millisecond defaults. That keeps every write and wipe-all wait short enough that dozens of commands fit in the run. With these values every gap can be measured from the select line to the cycle, and both organisations and both instruction lengths can be reached in one run. A model in the bench answers reads from its own memory image, so the address actually sent and the shifting in of data are both exposed.

// File: rtl/uwire_pkg.sv
package uwire_pkg;
  typedef enum logic [2:0] {
    OP_RD     = 3'd0,
    OP_WR     = 3'd1,
    OP_UNLOCK = 3'd2,
    OP_LOCK   = 3'd3,
    OP_WIPE   = 3'd4
  } uw_op_e;

  localparam int CMD_MAX  = 10;                       // byte-mode instruction
  localparam int DATA_MAX = 16;                       // widest data word
  localparam int FRAME_W  = CMD_MAX - 1 + DATA_MAX;   // longest serial frame
  localparam int LEN_W    = $clog2(FRAME_W + 1);
  localparam int CAPACITY = 128;                      // bytes
endpackage

// File: rtl/uwire_frame.sv
module uwire_frame
  import uwire_pkg::*;
(
  input  uw_op_e                 op,
  input  logic [6:0]             offset,
  input  logic [15:0]            wdata,
  input  logic                   x16,
  input  logic                   long_instr,
  output logic [FRAME_W-1:0]     frame,
  output logic [LEN_W-1:0]       tx_len,
  output logic [LEN_W-1:0]       rx_len
);
  logic [1:0]         opc, sub;
  logic               special;
  logic [6:0]         a7;
  logic [5:0]         a6;
  logic [9:0]         cmd10;
  logic [8:0]         cmd9;
  logic [FRAME_W-1:0] raw;
  logic [LEN_W-1:0]   len;

  always_comb begin
    special = (op == OP_UNLOCK) || (op == OP_LOCK) || (op == OP_WIPE);
    case (op)
      OP_RD:   opc = 2'b10;
      OP_WR:   opc = 2'b01;
      default: opc = 2'b00;
    endcase
    case (op)
      OP_UNLOCK: sub = 2'b11;
      OP_WIPE:   sub = 2'b10;
      default:   sub = 2'b00;
    endcase
    a7    = special ? {sub, 5'b0} : offset;
    a6    = special ? {sub, 4'b0} : offset[6:1];
    cmd10 = {1'b1, opc, a7};
    cmd9  = {1'b1, opc, a6};
    if (x16) begin
      raw = FRAME_W'(cmd9);
      len = LEN_W'(9);
    end else begin
      raw = FRAME_W'(cmd10);
      len = LEN_W'(10);
    end
    if (op == OP_WR) begin
      if (x16) begin
        raw = {cmd9, wdata};
        len = LEN_W'(25);
      end else begin
        raw = FRAME_W'({cmd10, wdata[7:0]});
        len = LEN_W'(18);
      end
    end
    if (special && long_instr) begin
      raw = {raw[FRAME_W-3:0], 2'b00};
      len = len + LEN_W'(2);
    end
    rx_len = (op == OP_RD) ? (x16 ? LEN_W'(16) : LEN_W'(8)) : '0;
    frame  = raw << (LEN_W'(FRAME_W) - len);
    tx_len = len;
  end
endmodule

// File: rtl/uwire_shifter.sv
module uwire_shifter
  import uwire_pkg::*;
#(
  parameter int SK_HALF = 50
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic [LEN_W-1:0]   tx_len,
  input  logic [LEN_W-1:0]   rx_len,
  input  logic               ee_do,
  output logic               active,
  output logic               sk,
  output logic               di,
  output logic               fin,
  output logic [15:0]        rx_data
);
  localparam int HC_W = (SK_HALF > 1) ? $clog2(SK_HALF) : 1;

  logic               act_q, act_n, sk_q, sk_n, fin_q, fin_n, tick;
  logic [HC_W-1:0]    half_q, half_n;
  logic [LEN_W-1:0]   bit_q, bit_n, txl_q, txl_n, tot_q, tot_n;
  logic [FRAME_W-1:0] sh_q, sh_n;
  logic [15:0]        rx_q, rx_n;

  always_comb begin
    act_n = act_q; sk_n = sk_q; half_n = half_q; bit_n = bit_q;
    sh_n = sh_q; rx_n = rx_q; txl_n = txl_q; tot_n = tot_q; fin_n = 1'b0;
    tick = act_q && (half_q == HC_W'(SK_HALF - 1));
    if (start) begin
      act_n = 1'b1; sk_n = 1'b0; half_n = '0; bit_n = '0;
      sh_n = frame; rx_n = '0; txl_n = tx_len; tot_n = tx_len + rx_len;
    end else if (act_q) begin
      half_n = tick ? '0 : half_q + 1'b1;
      if (tick) begin
        if (!sk_q) begin
          sk_n = 1'b1;
          if (bit_q >= txl_q) rx_n = {rx_q[14:0], ee_do};
        end else begin
          sk_n  = 1'b0;
          sh_n  = sh_q << 1;
          bit_n = bit_q + 1'b1;
          if (bit_q == tot_q - 1'b1) begin
            act_n = 1'b0;
            fin_n = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; sk_q <= 1'b0; half_q <= '0; bit_q <= '0; sh_q <= '0;
      rx_q <= '0; txl_q <= '0; tot_q <= '0; fin_q <= 1'b0;
    end else begin
      act_q <= act_n; sk_q <= sk_n; half_q <= half_n; bit_q <= bit_n; sh_q <= sh_n;
      rx_q <= rx_n; txl_q <= txl_n; tot_q <= tot_n; fin_q <= fin_n;
    end
  end

  assign active  = act_q;
  assign sk      = sk_q;
  assign di      = act_q & sh_q[FRAME_W-1];
  assign fin     = fin_q;
  assign rx_data = rx_q;

  a_r12_sk_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> !sk_q);
  a_r12_di_held_high_sk: assert property (@(posedge clk) disable iff (!rst_n)
    (sk_q && $past(sk_q)) |-> $stable(di));
endmodule

// File: rtl/uwire_timer.sv
module uwire_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             busy
);
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load)             cnt_n = len;
    else if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign busy = (cnt_q != '0);

  a_r8_wait_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/uwire_eeprom_ctrl.sv
module uwire_eeprom_ctrl
  import uwire_pkg::*;
#(
  parameter int SK_HALF       = 50,
  parameter int CS_IDLE_CYC   = 25,
  parameter int PROG_WAIT_CYC = 600000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_x16,
  input  logic        long_instr,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_op,
  input  logic [7:0]  req_offset,
  input  logic [15:0] req_wdata,
  output logic        done,
  output logic        err,
  output logic [15:0] rdata,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do
);
  localparam int TMR_MAX = (PROG_WAIT_CYC > CS_IDLE_CYC) ? PROG_WAIT_CYC : CS_IDLE_CYC;
  localparam int TW      = $clog2(TMR_MAX + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_WAIT} st_e;

  logic [1:0]         rs_q;
  logic               rst_i;
  st_e                st_q, st_n;
  uw_op_e             op;
  logic               bad, start, tmr_load, tmr_busy, sh_act, sh_fin;
  logic               done_q, done_n, err_q, err_n, is_rd_q, is_rd_n, slow_q, slow_n;
  logic [15:0]        rdata_q, rdata_n, rx;
  logic [TW-1:0]      tmr_len;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   tx_len, rx_len;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  assign op  = uw_op_e'(req_op);
  assign bad = (req_op > 3'd4) ||
               (((op == OP_RD) || (op == OP_WR)) && (req_offset >= 8'(CAPACITY)));

  uwire_frame u_frame (
    .op(op), .offset(req_offset[6:0]), .wdata(req_wdata), .x16(mode_x16),
    .long_instr(long_instr), .frame(frame), .tx_len(tx_len), .rx_len(rx_len)
  );

  uwire_shifter #(.SK_HALF(SK_HALF)) u_shift (
    .clk(clk), .rst_n(rst_i), .start(start), .frame(frame), .tx_len(tx_len),
    .rx_len(rx_len), .ee_do(ee_do), .active(sh_act), .sk(ee_sk), .di(ee_di),
    .fin(sh_fin), .rx_data(rx)
  );

  uwire_timer #(.CNT_W(TW)) u_timer (
    .clk(clk), .rst_n(rst_i), .load(tmr_load), .len(tmr_len), .busy(tmr_busy)
  );

  always_comb begin
    st_n = st_q; done_n = 1'b0; err_n = 1'b0; rdata_n = rdata_q;
    is_rd_n = is_rd_q; slow_n = slow_q; start = 1'b0; tmr_load = 1'b0;
    tmr_len = slow_q ? TW'(PROG_WAIT_CYC) : TW'(CS_IDLE_CYC);
    case (st_q)
      ST_IDLE: if (req_valid) begin
        if (bad) begin
          done_n = 1'b1;
          err_n  = 1'b1;
        end else begin
          start   = 1'b1;
          st_n    = ST_SHIFT;
          is_rd_n = (op == OP_RD);
          slow_n  = (op == OP_WR) || (op == OP_WIPE);
        end
      end
      ST_SHIFT: if (sh_fin) begin
        st_n     = ST_WAIT;
        tmr_load = 1'b1;
        done_n   = 1'b1;
        if (is_rd_q) rdata_n = rx;
      end
      default: if (!tmr_busy) st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q <= ST_IDLE; done_q <= 1'b0; err_q <= 1'b0; rdata_q <= '0;
      is_rd_q <= 1'b0; slow_q <= 1'b0;
    end else begin
      st_q <= st_n; done_q <= done_n; err_q <= err_n; rdata_q <= rdata_n;
      is_rd_q <= is_rd_n; slow_q <= slow_n;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign rdata     = rdata_q;
  assign ee_cs     = sh_act;

  a_r11_no_accept_on_wire: assert property (@(posedge clk) disable iff (!rst_i)
    ee_cs |-> !req_ready);
  a_r8_wait_keeps_quiet: assert property (@(posedge clk) disable iff (!rst_i)
    tmr_busy |-> (!ee_cs && !req_ready));
  a_r10_err_only_with_done: assert property (@(posedge clk) disable iff (!rst_i)
    err |-> done);
  a_r7_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_i)
    (done && !err) |=> !done);
endmodule

// File: tb/uwire_eeprom_ctrl_tb_top.sv
module uwire_eeprom_ctrl_tb_top;
  localparam int SKH = 2, IDLE = 5, PROG = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_x16 = 1'b0, long_instr = 1'b0, req_valid = 1'b0, ee_do = 1'b0;
  logic [2:0]  req_op = '0;
  logic [7:0]  req_offset = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, done, err, ee_cs, ee_sk, ee_di;
  logic [15:0] rdata;

  uwire_eeprom_ctrl #(.SK_HALF(SKH), .CS_IDLE_CYC(IDLE), .PROG_WAIT_CYC(PROG)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_x16(mode_x16), .long_instr(long_instr),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_offset(req_offset), .req_wdata(req_wdata), .done(done), .err(err),
    .rdata(rdata), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  logic [7:0]  mem8 [128];
  logic [15:0] mem16 [64];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model seen on the wire
  logic [31:0] cap = '0;
  int          nbits = 0, cs_rises = 0;
  always @(posedge ee_cs or posedge ee_sk) begin
    if (ee_sk) begin
      cap   = {cap[30:0], ee_di};
      nbits = nbits + 1;
    end else begin
      cap = '0; nbits = 0; cs_rises++;
    end
  end

  logic        m_rd = 1'b0;
  logic [15:0] m_word = '0;
  always @(negedge ee_sk) begin
    automatic int cl = mode_x16 ? 9 : 10;
    automatic int rl = mode_x16 ? 16 : 8;
    if (nbits == cl) begin
      m_rd   = cap[cl-1] && (cap[cl-2 -: 2] == 2'b10);
      m_word = mode_x16 ? mem16[cap[5:0]] : {8'h00, mem8[cap[6:0]]};
    end
    if (m_rd && nbits >= cl && nbits < cl + rl) ee_do = m_word[rl-1-(nbits-cl)];
    else ee_do = 1'b0;
  end

  // select gap and signal-order monitors
  int  need = 0, low_cnt = 0, r12_bad = 0, r11_bad = 0;
  bit  need_slow = 0, prev_cs = 0, prev_sk = 0, prev_di = 0;
  always @(negedge clk) begin
    if (ee_cs && !prev_cs && need > 0)
      chk(low_cnt >= need, need_slow ? "R8" : "R9", "select low gap", low_cnt, need);
    if (ee_cs) low_cnt = 0; else low_cnt++;
    if (prev_sk && ee_sk && (ee_di != prev_di)) r12_bad++;
    if (!ee_cs && ee_sk) r12_bad++;
    if (ee_cs && req_ready) r11_bad++;
    prev_cs = ee_cs; prev_sk = ee_sk; prev_di = ee_di;
  end

  function automatic void exp_frame(input int op, input logic [7:0] off, input logic [15:0] wd,
                                    output logic [31:0] b, output int n);
    logic [1:0] opc, sub;
    bit spec;
    opc  = (op == 0) ? 2'b10 : (op == 1) ? 2'b01 : 2'b00;
    sub  = (op == 2) ? 2'b11 : (op == 4) ? 2'b10 : 2'b00;
    spec = (op >= 2);
    if (!mode_x16) begin
      b = {22'b0, 1'b1, opc, (spec ? {sub, 5'b0} : off[6:0])}; n = 10;
    end else begin
      b = {23'b0, 1'b1, opc, (spec ? {sub, 4'b0} : off[6:1])}; n = 9;
    end
    if (op == 1) begin
      if (mode_x16) begin b = (b << 16) | wd; n += 16; end
      else          begin b = (b << 8) | wd[7:0]; n += 8; end
    end
    if (spec && long_instr) begin b = b << 2; n += 2; end
    if (op == 0) begin b = b << (mode_x16 ? 16 : 8); n += mode_x16 ? 16 : 8; end
  endfunction

  task automatic issue(input int op, input logic [7:0] off, input logic [15:0] wd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op[2:0]; req_offset = off; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_cmd(input int op, input logic [7:0] off, input logic [15:0] wd,
                         input string req);
    logic [31:0] eb;
    logic [15:0] er;
    int en, t;
    exp_frame(op, off, wd, eb, en);
    er = mode_x16 ? mem16[off[6:1]] : {8'h00, mem8[off[6:0]]};
    issue(op, off, wd);
    t = 0;
    while (!done && t < 400) begin @(negedge clk); t++; end
    chk(done && !err, req, "done without err", {done, err}, 2'b10);
    chk(nbits == en, req, "frame length", nbits, en);
    chk(cap == eb, req, "frame bits", cap, eb);
    if (op == 0) chk(rdata == er, "R7", "read data", rdata, er);
    @(negedge clk);
    chk(!done, "R7", "done lasts one cycle", done, 0);
    if (op == 1) begin
      if (mode_x16) mem16[off[6:1]] = wd; else mem8[off[6:0]] = wd[7:0];
    end
    if (op == 4) begin
      foreach (mem8[i]) mem8[i] = 8'hFF;
      foreach (mem16[i]) mem16[i] = 16'hFFFF;
    end
    need_slow = (op == 1) || (op == 4);
    need = need_slow ? PROG : IDLE;
  endtask

  task automatic run_reject(input int op, input logic [7:0] off);
    int r0;
    r0 = cs_rises;
    issue(op, off, 16'h0);
    chk(done && err, "R10", "rejected with err", {done, err}, 2'b11);
    repeat (3) @(negedge clk);
    chk(cs_rises == r0, "R10", "no select for rejected", cs_rises, r0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL R13 watchdog: cycles=%0d expected<150000", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    foreach (mem8[i]) mem8[i] = 8'h00;
    foreach (mem16[i]) mem16[i] = 16'h0000;
    repeat (3) @(negedge clk);
    chk(!ee_cs && !ee_sk && !done, "R13", "outputs in reset", {ee_cs, ee_sk, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && !ee_cs && !ee_sk && !done, "R13", "state after reset",
        {req_ready, ee_cs, ee_sk, done}, 4'b1000);

    // byte mode, short instructions (R1, R2, R4, R6, R7, R8, R9)
    run_cmd(2, 8'h00, 16'h0, "R4");
    run_cmd(1, 8'h05, 16'h00A5, "R6");
    run_cmd(1, 8'h7F, 16'h003C, "R2");
    run_cmd(3, 8'h00, 16'h0, "R4");
    run_cmd(0, 8'h05, 16'h0, "R1");
    run_cmd(0, 8'h7F, 16'h0, "R2");
    run_cmd(4, 8'h00, 16'h0, "R4");
    run_cmd(0, 8'h05, 16'h0, "R7");

    // long instructions (R5)
    long_instr = 1'b1;
    run_cmd(2, 8'h00, 16'h0, "R5");
    run_cmd(3, 8'h00, 16'h0, "R5");
    run_cmd(4, 8'h00, 16'h0, "R5");
    run_cmd(1, 8'h11, 16'h005A, "R5");
    run_cmd(0, 8'h11, 16'h0, "R5");
    long_instr = 1'b0;

    // rejection (R10)
    run_reject(0, 8'd128);
    run_reject(1, 8'hFF);
    run_reject(6, 8'h01);

    // word mode (R3, R6, R7)
    mode_x16 = 1'b1;
    run_cmd(1, 8'h0A, 16'h1234, "R6");
    run_cmd(0, 8'h0B, 16'h0, "R3");
    run_cmd(1, 8'h7F, 16'h8001, "R3");
    run_cmd(0, 8'h7E, 16'h0, "R3");

    // random mix
    for (int k = 0; k < 40; k++) begin
      automatic int r = $urandom_range(0, 9);
      automatic int op = (r < 4) ? 0 : (r < 7) ? 1 : r - 5;
      mode_x16   = $urandom_range(0, 1);
      long_instr = $urandom_range(0, 1);
      run_cmd(op, 8'($urandom_range(0, 127)), 16'($urandom), "R1");
    end

    chk(r11_bad == 0, "R11", "ready low while select high", r11_bad, 0);
    chk(r12_bad == 0, "R12", "data/clock ordering", r12_bad, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule